// File: doc/BRIEF.md
# Loopback Cell Counter and Alarm Status Register

This block is a small status unit for a cell-based interface bridge. It counts loopback cells as they leave the device and keeps an 8-bit alarm register. Each alarm bit is driven by an event strobe or a level condition that comes from the surrounding datapath. Both values are exposed on a simple read port. A read returns the current value one cycle later and clears the register that was read in the same cycle.

The alarm register mixes two kinds of bit. Most bits latch a single-cycle event and stay set until they are read. The PDU-length and soft-overflow bits are set again on every cycle in which their condition is true, so after a clearing read they come straight back if the cause is still present. The bit that reports a change in the local counter is set by the counter itself. Every alarm bit is ANDed with its own enable, and the results are ORed into one registered interrupt line.

Top module: `lbk_alarm_regs`

## Requirements
- R1: The loopback counter resets to 0x00. A read with `rd_sel`=0 returns its value on `rd_data` one cycle later and clears it.
- R2: The counter increments only in a cycle in which both `lbk_cell_out` and `lbk_enable` are high.
- R3: The counter never wraps. At 0xFF it holds until a read clears it.
- R4: The alarm register resets to 0x00. A read with `rd_sel`=1 returns it one cycle later and clears it. Its bits, MSB first, are: [7] PDU length, [6] bad transfer restart, [5] local count changed, [4] remote count changed, [3] parity, [2] FIB overflow, [1] soft overflow, [0] hard overflow.
- R5: Bit 7 is set in every cycle in which `pdu_len_cfg` exceeds 64. It is not set by lengths of 64 or below.
- R6: Bit 6 is set only when `phy_mode` is high and `resume_stb` arrives with `resume_addr` different from `first_addr`.
- R7: Bit 5 is set in any cycle in which the counter takes a new value.
- R8: Bits 4, 3 and 2 latch the strobes `remote_cnt_chg`, `parity_err` and `fib_ovf_try` respectively.
- R9: Bit 1 is set in every cycle in which any bit of `soft_ovf_flags` is high.
- R10: Bit 0 is set when `q_push` arrives while `q_fill` is at or above 159.
- R11: `irq` is a registered OR of (alarm AND `irq_en`). It falls in the cycle after a clearing read unless a new set arrives.
- R12: An event in the same cycle as a clearing read is kept. The read returns the old value, and the register then holds the event: the counter reads 1, and the alarm bit stays set.
- R13: `rd_data` holds its last value when no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Read strobe (clears the selected register) |
| rd_sel | input | 1 | 0 selects the counter, 1 selects the alarm register |
| rd_data | output | 8 | Registered read data |
| lbk_cell_out | input | 1 | A loopback cell was read out |
| lbk_enable | input | 1 | Loopback mode is enabled |
| remote_cnt_chg | input | 1 | Another loopback counter changed |
| parity_err | input | 1 | Parity error on an incoming cell byte |
| phy_mode | input | 1 | Block acts as the PHY side |
| resume_stb | input | 1 | A suspended transfer is resumed |
| resume_addr | input | 5 | PHY address used at resume |
| first_addr | input | 5 | PHY address selected originally |
| pdu_len_cfg | input | 8 | Configured PDU length in bytes |
| fib_ovf_try | input | 1 | FIB queue overflow attempt |
| soft_ovf_flags | input | 4 | Per-queue soft overflow flags |
| q_push | input | 1 | A cell is pushed into the shared buffer |
| q_fill | input | 8 | Shared buffer fill level in cells |
| irq_en | input | 8 | Per-bit interrupt enables |
| irq | output | 1 | Interrupt |

## Verification
The bench uses the default parameters: an 8-bit counter, four soft-overflow flags, 5-bit PHY addresses, a PDU limit of 64 and a hard limit of 159. With an 8-bit counter, saturation at 0xFF is reached with a few hundred increments. An 8-bit fill input lets the bench drive the boundary values 158, 159 and 160 directly. The PDU-length edge at 64/65 and address mismatches with `phy_mode` both low and high are driven on purpose. Events that land in the same cycle as a clearing read are checked against the model on every clock.

// File: rtl/lbk_alarm_pkg.sv
// Package: shared widths and alarm bit positions for the loopback/alarm block.
// Assumes: bit positions are fixed, because software decodes them.
package lbk_alarm_pkg;
    localparam int ALARM_W     = 8;
    localparam int BIT_PDU_LEN = 7;
    localparam int BIT_XFER    = 6;
    localparam int BIT_LCL_CHG = 5;
    localparam int BIT_RMT_CHG = 4;
    localparam int BIT_PARITY  = 3;
    localparam int BIT_FIB_OVF = 2;
    localparam int BIT_SOFT    = 1;
    localparam int BIT_HARD    = 0;
    localparam logic SEL_COUNT = 1'b0;
    localparam logic SEL_ALARM = 1'b1;
endpackage

// File: rtl/lbk_sat_counter.sv
// Saturating clear-on-read event counter.
// Does: counts inc strobes, sticks at all-ones, clears on clr. An inc in the
//       same cycle as clr leaves the value at 1.
// Assumes: clr is a single-cycle strobe from the read port.
module lbk_sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] cnt,
    output logic         changed
);
    localparam logic [W-1:0] MAX_VAL = {W{1'b1}};

    logic [W-1:0] base;

    // Purpose: the value left after an optional clear.
    always_comb base = clr ? '0 : cnt;

    // Purpose: flag an increment that actually moves the value.
    always_comb changed = inc && (base != MAX_VAL);

    // Purpose: counter register.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (changed) cnt <= base + 1'b1;
        else              cnt <= base;
    end

    AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == MAX_VAL && !clr) |=> cnt == MAX_VAL); // R3
    AST_CNT_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !clr) |=> $stable(cnt)); // R2
    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !inc) |=> cnt == '0); // R1
    AST_CNT_CLEAR_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && inc) |=> cnt == W'(1)); // R12
endmodule

// File: rtl/alarm_set_decode.sv
// Alarm set-vector decode.
// Does: turns event strobes and level conditions into one set vector per
//       cycle, in the fixed bit order from lbk_alarm_pkg.
// Assumes: all inputs are synchronous to clk.
module alarm_set_decode
    import lbk_alarm_pkg::*;
#(
    parameter int PDU_W      = 8,
    parameter int PDU_MAX    = 64,
    parameter int FILL_W     = 8,
    parameter int HARD_LIMIT = 159,
    parameter int NQ         = 4,
    parameter int PHY_AW     = 5
) (
    input  logic               lcl_changed,
    input  logic               remote_cnt_chg,
    input  logic               parity_err,
    input  logic               phy_mode,
    input  logic               resume_stb,
    input  logic [PHY_AW-1:0]  resume_addr,
    input  logic [PHY_AW-1:0]  first_addr,
    input  logic [PDU_W-1:0]   pdu_len_cfg,
    input  logic               fib_ovf_try,
    input  logic [NQ-1:0]      soft_ovf_flags,
    input  logic               q_push,
    input  logic [FILL_W-1:0]  q_fill,
    output logic [ALARM_W-1:0] set_vec
);
    localparam logic [PDU_W-1:0]  PDU_LIM  = PDU_W'(PDU_MAX);
    localparam logic [FILL_W-1:0] FILL_LIM = FILL_W'(HARD_LIMIT);

    // Purpose: build the per-bit set conditions.
    always_comb begin
        set_vec              = '0;
        set_vec[BIT_PDU_LEN] = pdu_len_cfg > PDU_LIM;
        set_vec[BIT_XFER]    = phy_mode && resume_stb && (resume_addr != first_addr);
        set_vec[BIT_LCL_CHG] = lcl_changed;
        set_vec[BIT_RMT_CHG] = remote_cnt_chg;
        set_vec[BIT_PARITY]  = parity_err;
        set_vec[BIT_FIB_OVF] = fib_ovf_try;
        set_vec[BIT_SOFT]    = |soft_ovf_flags;
        set_vec[BIT_HARD]    = q_push && (q_fill >= FILL_LIM);
    end
endmodule

// File: rtl/alarm_status_reg.sv
// Clear-on-read alarm register with masked interrupt.
// Does: ORs the set vector into the held bits, clears on clr (a set in the
//       same cycle wins), and registers the OR of the enabled bits as irq.
// Assumes: set_vec bits for level conditions are asserted every cycle.
module alarm_status_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic         clr,
    input  logic [W-1:0] irq_en,
    output logic [W-1:0] alarm,
    output logic         irq
);
    logic [W-1:0] alarm_nxt;

    // Purpose: next alarm value after clear and new sets.
    always_comb alarm_nxt = (clr ? '0 : alarm) | set_vec;

    // Purpose: alarm and interrupt registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm <= '0;
            irq   <= 1'b0;
        end else begin
            alarm <= alarm_nxt;
            irq   <= |(alarm_nxt & irq_en);
        end
    end

    AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((alarm & $past(alarm)) == $past(alarm))); // R8
    AST_ALARM_SET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((alarm & $past(set_vec)) == $past(set_vec))); // R12
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == '0) |=> !irq); // R11
endmodule

// File: rtl/lbk_alarm_regs.sv
// Top: loopback cell counter plus alarm status register with a read port.
// Does: rd_en with rd_sel picks the counter (0) or the alarm register (1).
//       The old value appears on rd_data next cycle and the register clears.
// Assumes: one read per cycle; the counter width equals the alarm width.
module lbk_alarm_regs
    import lbk_alarm_pkg::*;
#(
    parameter int PDU_W      = 8,
    parameter int PDU_MAX    = 64,
    parameter int FILL_W     = 8,
    parameter int HARD_LIMIT = 159,
    parameter int NQ         = 4,
    parameter int PHY_AW     = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic               rd_sel,
    output logic [ALARM_W-1:0] rd_data,
    input  logic               lbk_cell_out,
    input  logic               lbk_enable,
    input  logic               remote_cnt_chg,
    input  logic               parity_err,
    input  logic               phy_mode,
    input  logic               resume_stb,
    input  logic [PHY_AW-1:0]  resume_addr,
    input  logic [PHY_AW-1:0]  first_addr,
    input  logic [PDU_W-1:0]   pdu_len_cfg,
    input  logic               fib_ovf_try,
    input  logic [NQ-1:0]      soft_ovf_flags,
    input  logic               q_push,
    input  logic [FILL_W-1:0]  q_fill,
    input  logic [ALARM_W-1:0] irq_en,
    output logic               irq
);
    logic [ALARM_W-1:0] cnt;
    logic [ALARM_W-1:0] alarm;
    logic [ALARM_W-1:0] set_vec;
    logic               cnt_changed;
    logic               clr_cnt;
    logic               clr_alarm;
    logic               cnt_inc;

    // Purpose: decode read clears and the counter increment.
    always_comb begin
        clr_cnt   = rd_en && (rd_sel == SEL_COUNT);
        clr_alarm = rd_en && (rd_sel == SEL_ALARM);
        cnt_inc   = lbk_cell_out && lbk_enable;
    end

    lbk_sat_counter #(.W(ALARM_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc(cnt_inc), .clr(clr_cnt),
        .cnt(cnt), .changed(cnt_changed)
    );

    alarm_set_decode #(
        .PDU_W(PDU_W), .PDU_MAX(PDU_MAX), .FILL_W(FILL_W),
        .HARD_LIMIT(HARD_LIMIT), .NQ(NQ), .PHY_AW(PHY_AW)
    ) u_dec (
        .lcl_changed(cnt_changed), .remote_cnt_chg(remote_cnt_chg),
        .parity_err(parity_err), .phy_mode(phy_mode), .resume_stb(resume_stb),
        .resume_addr(resume_addr), .first_addr(first_addr),
        .pdu_len_cfg(pdu_len_cfg), .fib_ovf_try(fib_ovf_try),
        .soft_ovf_flags(soft_ovf_flags), .q_push(q_push), .q_fill(q_fill),
        .set_vec(set_vec)
    );

    alarm_status_reg #(.W(ALARM_W)) u_alm (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr(clr_alarm),
        .irq_en(irq_en), .alarm(alarm), .irq(irq)
    );

    // Purpose: registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= (rd_sel == SEL_ALARM) ? alarm : cnt;
    end

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)); // R13
    AST_LCL_CHG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != $past(cnt) && cnt != '0) |-> alarm[BIT_LCL_CHG]); // R7
    AST_XFER_NEEDS_PHY: assert property (@(posedge clk) disable iff (!rst_n)
        (!phy_mode && clr_alarm) |=> !alarm[BIT_XFER]); // R6
endmodule

// File: tb/lbk_alarm_regs_tb_top.sv
module lbk_alarm_regs_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_en = 0, rd_sel = 0;
    logic [7:0] rd_data;
    logic lbk_cell_out = 0, lbk_enable = 0, remote_cnt_chg = 0, parity_err = 0;
    logic phy_mode = 0, resume_stb = 0;
    logic [4:0] resume_addr = 0, first_addr = 0;
    logic [7:0] pdu_len_cfg = 8'd64;
    logic fib_ovf_try = 0;
    logic [3:0] soft_ovf_flags = 0;
    logic q_push = 0;
    logic [7:0] q_fill = 0;
    logic [7:0] irq_en = 0;
    logic irq;

    int n_checks = 0, n_fail = 0;
    string cur_req = "R1";
    bit done = 0;

    // reference model state
    int m_cnt = 0, m_alarm = 0, m_rd = 0, m_irq = 0;

    always #2.5 clk = ~clk;

    lbk_alarm_regs dut_i (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
        .lbk_cell_out(lbk_cell_out), .lbk_enable(lbk_enable),
        .remote_cnt_chg(remote_cnt_chg), .parity_err(parity_err),
        .phy_mode(phy_mode), .resume_stb(resume_stb), .resume_addr(resume_addr),
        .first_addr(first_addr), .pdu_len_cfg(pdu_len_cfg), .fib_ovf_try(fib_ovf_try),
        .soft_ovf_flags(soft_ovf_flags), .q_push(q_push), .q_fill(q_fill),
        .irq_en(irq_en), .irq(irq)
    );

    // Behavioural model from the requirements, advanced on each rising edge.
    always @(posedge clk) begin
        int c, a, s;
        bit chg;
        if (!rst_n) begin
            m_cnt <= 0; m_alarm <= 0; m_rd <= 0; m_irq <= 0;
        end else begin
            c = (rd_en && !rd_sel) ? 0 : m_cnt;
            chg = 0;
            if (lbk_cell_out && lbk_enable && c < 255) begin c = c + 1; chg = 1; end
            s = 0;
            if (pdu_len_cfg > 64) s |= 128;
            if (phy_mode && resume_stb && resume_addr != first_addr) s |= 64;
            if (chg) s |= 32;
            if (remote_cnt_chg) s |= 16;
            if (parity_err) s |= 8;
            if (fib_ovf_try) s |= 4;
            if (soft_ovf_flags != 0) s |= 2;
            if (q_push && q_fill >= 159) s |= 1;
            a = ((rd_en && rd_sel) ? 0 : m_alarm) | s;
            if (rd_en) m_rd <= rd_sel ? m_alarm : m_cnt;
            m_cnt <= c;
            m_alarm <= a;
            m_irq <= ((a & irq_en) != 0) ? 1 : 0;
        end
    end

    // Compare on every falling edge.
    always @(negedge clk) begin
        if (!done) begin
            n_checks += 2;
            if (int'(rd_data) != m_rd) begin
                n_fail++;
                $display("FAIL %s rd_data actual=%0h expected=%0h t=%0t", cur_req, rd_data, m_rd, $time);
            end
            if (int'(irq) != m_irq) begin
                n_fail++;
                $display("FAIL %s irq actual=%0d expected=%0d t=%0t", cur_req, irq, m_irq, $time);
            end
        end
    end

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_strobes();
        rd_en = 0; lbk_cell_out = 0; remote_cnt_chg = 0; parity_err = 0;
        resume_stb = 0; fib_ovf_try = 0; q_push = 0;
    endtask

    task automatic do_read(logic sel);
        rd_en = 1; rd_sel = sel; step(); rd_en = 0; step();
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(5ns * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        step(3);
        rst_n = 1;
        cur_req = "R1"; step(); do_read(0); do_read(1);   // reset state, R4 too
        // R2: cells without enable are ignored, then counted with enable
        cur_req = "R2";
        lbk_cell_out = 1; step(5); lbk_cell_out = 0;
        do_read(0);
        lbk_enable = 1; lbk_cell_out = 1; step(7); lbk_cell_out = 0;
        cur_req = "R7"; do_read(1);
        cur_req = "R1"; do_read(0); do_read(0);
        // R3: saturation
        cur_req = "R3";
        lbk_cell_out = 1; step(300); lbk_cell_out = 0; step(2);
        do_read(0); do_read(0);
        // R12: event during clearing read of the counter
        cur_req = "R12";
        lbk_cell_out = 1; step(3);
        rd_en = 1; rd_sel = 0; step(); rd_en = 0; lbk_cell_out = 0; step();
        do_read(0);
        // R11: interrupt masking and deassert after read
        cur_req = "R11";
        irq_en = 8'h08; parity_err = 1; step(); parity_err = 0; step(3);
        do_read(1); step(2);
        irq_en = 8'h10; parity_err = 1; step(); parity_err = 0; step(2);
        do_read(1);
        irq_en = 8'hFF;
        // R8: sticky event bits
        cur_req = "R8";
        remote_cnt_chg = 1; step(); remote_cnt_chg = 0;
        fib_ovf_try = 1; step(); fib_ovf_try = 0; step(4);
        do_read(1); do_read(1);
        // R5: PDU length boundary
        cur_req = "R5";
        pdu_len_cfg = 8'd64; step(2); do_read(1);
        pdu_len_cfg = 8'd65; step(2); do_read(1); do_read(1);
        pdu_len_cfg = 8'd40; step(); do_read(1); do_read(1);
        // R6: illegal restart
        cur_req = "R6";
        first_addr = 5'd3; resume_addr = 5'd7; phy_mode = 0;
        resume_stb = 1; step(); resume_stb = 0; do_read(1);
        phy_mode = 1; resume_addr = 5'd3;
        resume_stb = 1; step(); resume_stb = 0; do_read(1);
        resume_addr = 5'd9; resume_stb = 1; step(); resume_stb = 0; do_read(1);
        // R9: soft overflow level
        cur_req = "R9";
        soft_ovf_flags = 4'b0100; step(2); do_read(1); do_read(1);
        soft_ovf_flags = 0; step(); do_read(1); do_read(1);
        // R10: hard limit boundary
        cur_req = "R10";
        q_fill = 8'd158; q_push = 1; step(); q_push = 0; do_read(1);
        q_fill = 8'd159; q_push = 1; step(); q_push = 0; do_read(1);
        q_fill = 8'd200; step(); do_read(1);
        q_fill = 8'd160; q_push = 1; step(); q_push = 0; do_read(1);
        // R12: sticky event during clearing read of alarms
        cur_req = "R12";
        parity_err = 1; step(); parity_err = 0;
        rd_en = 1; rd_sel = 1; fib_ovf_try = 1; step();
        rd_en = 0; fib_ovf_try = 0; step(); do_read(1);
        // R13: hold between reads, random traffic
        cur_req = "R13";
        for (int i = 0; i < 2000; i++) begin
            rd_en          = ($urandom % 4) == 0;
            rd_sel         = $urandom % 2;
            lbk_enable     = ($urandom % 4) != 0;
            lbk_cell_out   = $urandom % 2;
            remote_cnt_chg = ($urandom % 16) == 0;
            parity_err     = ($urandom % 16) == 0;
            phy_mode       = $urandom % 2;
            resume_stb     = ($urandom % 8) == 0;
            resume_addr    = 5'($urandom % 4);
            first_addr     = 5'($urandom % 4);
            pdu_len_cfg    = 8'(60 + $urandom % 8);
            fib_ovf_try    = ($urandom % 16) == 0;
            soft_ovf_flags = (($urandom % 8) == 0) ? 4'($urandom) : 4'h0;
            q_push         = $urandom % 2;
            q_fill         = 8'(156 + $urandom % 6);
            irq_en         = 8'($urandom);
            step();
        end
        clear_strobes();
        step(3);
        finish_run();
    end
endmodule